// File: doc/BRIEF.md
# Register-Mapped GPIO Controller with Edge-Capture Interrupt

This block gives software control over a bank of up to 32 general-purpose pins through a small 32-bit register bus. For each pin, software chooses whether it is an input or an output. It sets the value that an output drives and reads back the level of every pin. A write-mask register lets one data write touch only selected bits.

Every pin also feeds a change detector. The pad level first passes through a two-flop synchronizer. Any transition, rising or falling, then sets a sticky change bit for that pin. Software acknowledges a change by writing 1 to its bit. A per-pin enable decides which change bits take part in the single level-sensitive interrupt line. An interrupt-type register is kept as plain storage, because detection always works on both edges.

Top module: `gpio_ctrl`

## Requirements
- R1: After reset, every register reads zero, `pin_oe` is all zero and `irq` is low.
- R2: The direction register is at offset 0x00. A bit set to 1 makes that pin an output, so its `pin_oe` bit is high. In the cycle after the direction write, `pin_out` already carries the value stored earlier in the data register.
- R3: The data register is at offset 0x04. A read returns, for each output pin, the stored data bit. For each input pin, it returns the pad level after a two-flop synchronizer.
- R4: The write-mask register is at offset 0x10. While it is nonzero, a data write changes only the bits set in the mask. While it is zero, a data write changes every bit.
- R5: The change register is at offset 0x0C. Either a rising or a falling transition of a synchronized pin sets that pin's bit, and the bit stays set until it is cleared.
- R6: Writing 1 to a change bit clears it. Writing 0 leaves it unchanged. If a new edge of a pin arrives in the same cycle as the clear of its bit, the bit stays set.
- R7: The enable register is at offset 0x08. `irq` is high exactly while at least one pin has both its change bit and its enable bit set.
- R8: The interrupt-type register is at offset 0x14. It stores and returns whatever is written to it, and its value has no effect on edge capture.
- R9: Register bits at or above the pin count `NPINS` read as zero, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_en | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| pin_in | input | NPINS | Pad levels (asynchronous) |
| pin_out | output | NPINS | Output drive values |
| pin_oe | output | NPINS | Output enables (1 = drive) |
| irq | output | 1 | Combined level interrupt |

## Verification
The hardest case to reach is a new edge on a pin in the very cycle that software clears that pin's change bit. The edge pulse lasts one cycle and lies two synchronizer stages behind the pad. The stimulus therefore toggles the pin, counts two rising clock edges, and starts the clearing write on the following falling edge. That places the write's commit edge on the cycle the edge pulse is live. A companion clear without an edge shows that the same write does clear the bit when nothing competes with it.

// File: rtl/gpio_ctrl_pkg.sv
`timescale 1ns/1ps
package gpio_ctrl_pkg;
    localparam int unsigned BUS_W  = 32;
    localparam int unsigned ADDR_W = 5;

    typedef enum logic [ADDR_W-1:0] {
        OFS_DIR   = 5'h00,
        OFS_DATA  = 5'h04,
        OFS_IEN   = 5'h08,
        OFS_CHG   = 5'h0C,
        OFS_WMASK = 5'h10,
        OFS_ITYPE = 5'h14
    } reg_ofs_e;
endpackage

// File: rtl/gpio_sync_edge.sv
`timescale 1ns/1ps
// Two-stage synchronizer per pin followed by a both-edge detector.
module gpio_sync_edge #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw_i,
    output logic [W-1:0] level_o,
    output logic [W-1:0] edge_o
);
    typedef struct packed {
        logic [W-1:0] meta;
        logic [W-1:0] stable;
        logic [W-1:0] prev;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.meta   = raw_i;
        st_d.stable = st_q.meta;
        st_d.prev   = st_q.stable;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign level_o = st_q.stable;
    assign edge_o  = st_q.stable ^ st_q.prev;
endmodule

// File: rtl/gpio_irq_merge.sv
`timescale 1ns/1ps
// Masks pending change bits with their enables and merges them into one line.
module gpio_irq_merge #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] pending_i,
    input  logic [W-1:0] enable_i,
    output logic         irq_o
);
    logic [W-1:0] live;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign live[i] = pending_i[i] & enable_i[i];
    end

    assign irq_o = |live;
endmodule

// File: rtl/gpio_ctrl.sv
`timescale 1ns/1ps
module gpio_ctrl
    import gpio_ctrl_pkg::*;
#(
    parameter int unsigned NPINS = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic [NPINS-1:0]  pin_in,
    output logic [NPINS-1:0]  pin_out,
    output logic [NPINS-1:0]  pin_oe,
    output logic              irq
);
    typedef struct packed {
        logic [NPINS-1:0] dir;
        logic [NPINS-1:0] dout;
        logic [NPINS-1:0] ien;
        logic [NPINS-1:0] chg;
        logic [NPINS-1:0] wmask;
        logic [NPINS-1:0] itype;
    } regs_t;

    regs_t regs_d, regs_q;

    logic [NPINS-1:0] pin_lvl;
    logic [NPINS-1:0] pin_edge;
    logic [NPINS-1:0] wbits;
    logic [NPINS-1:0] data_sel;
    logic             wr_go;
    logic             wdata_unused;

    assign wbits        = bus_wdata[NPINS-1:0];
    assign wr_go        = bus_en & bus_wr;
    assign wdata_unused = ^bus_wdata;

    gpio_sync_edge #(.W(NPINS)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .raw_i   (pin_in),
        .level_o (pin_lvl),
        .edge_o  (pin_edge)
    );

    always_comb begin
        regs_d = regs_q;
        data_sel = (|regs_q.wmask) ? regs_q.wmask : {NPINS{1'b1}};

        if (wr_go) begin
            unique case (bus_addr)
                OFS_DIR:   regs_d.dir   = wbits;
                OFS_DATA:  regs_d.dout  = (regs_q.dout & ~data_sel) | (wbits & data_sel);
                OFS_IEN:   regs_d.ien   = wbits;
                OFS_CHG:   regs_d.chg   = regs_q.chg & ~wbits;
                OFS_WMASK: regs_d.wmask = wbits;
                OFS_ITYPE: regs_d.itype = wbits;
                default:   ;
            endcase
        end

        // new edges are applied after any clear, so an edge wins a collision
        regs_d.chg = regs_d.chg | pin_edge;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            OFS_DIR:   bus_rdata[NPINS-1:0] = regs_q.dir;
            OFS_DATA:  bus_rdata[NPINS-1:0] = (regs_q.dir & regs_q.dout) | (~regs_q.dir & pin_lvl);
            OFS_IEN:   bus_rdata[NPINS-1:0] = regs_q.ien;
            OFS_CHG:   bus_rdata[NPINS-1:0] = regs_q.chg;
            OFS_WMASK: bus_rdata[NPINS-1:0] = regs_q.wmask;
            OFS_ITYPE: bus_rdata[NPINS-1:0] = regs_q.itype;
            default:   ;
        endcase
    end

    assign pin_out = regs_q.dout;
    assign pin_oe  = regs_q.dir;

    gpio_irq_merge #(.W(NPINS)) u_irq (
        .pending_i (regs_q.chg),
        .enable_i  (regs_q.ien),
        .irq_o     (irq)
    );
endmodule

// File: rtl/gpio_ctrl_chk.sv
`timescale 1ns/1ps
module gpio_ctrl_chk
    import gpio_ctrl_pkg::*;
#(
    parameter int unsigned NPINS = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_en,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [NPINS-1:0]  wr_bits,
    input logic [BUS_W-1:0]  bus_rdata,
    input logic [NPINS-1:0]  chg_q,
    input logic [NPINS-1:0]  ien_q,
    input logic [NPINS-1:0]  edge_w,
    input logic [NPINS-1:0]  pin_oe,
    input logic              irq
);
    logic wr_chg, wr_dir;
    assign wr_chg = bus_en && bus_wr && (bus_addr == OFS_CHG);
    assign wr_dir = bus_en && bus_wr && (bus_addr == OFS_DIR);

    // R2: a direction write shows on pin_oe one cycle later
    a_r2_dir_to_oe: assert property (@(posedge clk) disable iff (!rst_n)
        wr_dir |=> (pin_oe == $past(wr_bits)));

    // R5: an edge sets its change bit on the next cycle
    a_r5_edge_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (|edge_w) |=> ((chg_q & $past(edge_w)) == $past(edge_w)));

    // R5: without a clearing write, no change bit falls
    a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_chg |=> ((chg_q & $past(chg_q)) == $past(chg_q)));

    // R6: cleared bits without a competing edge are zero afterwards
    a_r6_w1c: assert property (@(posedge clk) disable iff (!rst_n)
        wr_chg |=> ((chg_q & $past(wr_bits & ~edge_w)) == '0));

    // R7: irq implies an enabled pending bit, and vice versa
    a_r7_irq_level: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (|(chg_q & ien_q)));

    if (NPINS < BUS_W) begin : g_hi
        // R9: unimplemented bits never read as one
        a_r9_hi_zero: assert property (@(posedge clk) disable iff (!rst_n)
            bus_rdata[BUS_W-1:NPINS] == '0);
    end
endmodule

bind gpio_ctrl gpio_ctrl_chk #(.NPINS(NPINS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_en    (bus_en),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .wr_bits   (bus_wdata[NPINS-1:0]),
    .bus_rdata (bus_rdata),
    .chg_q     (regs_q.chg),
    .ien_q     (regs_q.ien),
    .edge_w    (pin_edge),
    .pin_oe    (pin_oe),
    .irq       (irq)
);

// File: tb/gpio_ctrl_bench.sv
`timescale 1ns/1ps
module gpio_ctrl_bench;
    localparam int unsigned NP = 24;
    localparam logic [31:0] LOMASK = 32'h00FF_FFFF;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_en = 1'b0;
    logic          bus_wr = 1'b0;
    logic [4:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NP-1:0] pin_in = '0;
    logic [NP-1:0] pin_out;
    logic [NP-1:0] pin_oe;
    logic          irq;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    gpio_ctrl #(.NPINS(NP)) u_gpio_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(logic [4:0] a, logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_en = 1'b0;
    endtask

    task automatic settle();
        repeat (4) @(posedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        for (int a = 0; a <= 5'h14; a += 4) begin
            rd(a[4:0], v);
            check("R1 reg zero", v, 32'h0);
        end
        check("R1 pin_oe", {8'h0, pin_oe}, 32'h0);
        check("R1 irq", {31'h0, irq}, 32'h0);
    endtask

    task automatic t_direction();
        wr(5'h04, 32'h0000_0005);
        check("R2 no drive before dir", {8'h0, pin_oe}, 32'h0);
        wr(5'h00, 32'h0000_0001);
        check("R2 oe bit0", {8'h0, pin_oe}, 32'h1);
        check("R2 out holds stored data", {31'h0, pin_out[0]}, 32'h1);
    endtask

    task automatic t_data_read();
        logic [31:0] v;
        pin_in = 24'h0000_30;
        settle();
        rd(5'h04, v);
        check("R3 mixed read", v, 32'h0000_0031);
        pin_in = 24'h0;
        settle();
        wr(5'h0C, 32'hFFFF_FFFF);
    endtask

    task automatic t_wmask();
        logic [31:0] v;
        wr(5'h00, 32'h0000_00FF);
        wr(5'h04, 32'h0000_0000);
        wr(5'h10, 32'h0000_000F);
        wr(5'h04, 32'h0000_00FF);
        rd(5'h04, v);
        check("R4 masked write", v, 32'h0000_000F);
        wr(5'h10, 32'h0);
        wr(5'h04, 32'h0000_00A0);
        rd(5'h04, v);
        check("R4 zero mask full write", v, 32'h0000_00A0);
        wr(5'h00, 32'h0);
    endtask

    task automatic t_edges();
        logic [31:0] v;
        wr(5'h14, 32'h0);
        pin_in[3] = 1'b1;
        settle();
        rd(5'h0C, v);
        check("R5 rise sets", v, 32'h0000_0008);
        check("R8 itype zero still captures", v, 32'h0000_0008);
        wr(5'h0C, 32'h0000_0000);
        rd(5'h0C, v);
        check("R6 write zero keeps", v, 32'h0000_0008);
        wr(5'h0C, 32'h0000_0008);
        rd(5'h0C, v);
        check("R6 write one clears", v, 32'h0);
        pin_in[3] = 1'b0;
        settle();
        rd(5'h0C, v);
        check("R5 fall sets", v, 32'h0000_0008);
        repeat (6) @(posedge clk);
        rd(5'h0C, v);
        check("R5 sticky", v, 32'h0000_0008);
    endtask

    task automatic t_collision();
        logic [31:0] v;
        @(negedge clk);
        pin_in[3] = 1'b1;
        @(posedge clk);
        @(posedge clk);
        wr(5'h0C, 32'h0000_0008);
        rd(5'h0C, v);
        check("R6 edge wins over clear", v, 32'h0000_0008);
        wr(5'h0C, 32'h0000_0008);
        rd(5'h0C, v);
        check("R6 clear without edge", v, 32'h0);
    endtask

    task automatic t_irq();
        pin_in[1] = 1'b1;
        pin_in[5] = 1'b1;
        settle();
        check("R7 disabled no irq", {31'h0, irq}, 32'h0);
        wr(5'h08, 32'h0000_0022);
        check("R7 enabled irq", {31'h0, irq}, 32'h1);
        wr(5'h0C, 32'h0000_0002);
        check("R7 one still pending", {31'h0, irq}, 32'h1);
        wr(5'h0C, 32'h0000_0020);
        check("R7 all cleared", {31'h0, irq}, 32'h0);
        wr(5'h0C, 32'hFFFF_FFFF);
    endtask

    task automatic t_itype();
        logic [31:0] v;
        wr(5'h14, 32'h0000_1234);
        rd(5'h14, v);
        check("R8 itype storage", v, 32'h0000_1234);
        pin_in[7] = 1'b1;
        settle();
        rd(5'h0C, v);
        check("R8 capture unaffected", v & 32'h80, 32'h80);
    endtask

    task automatic t_upper();
        logic [31:0] v;
        wr(5'h00, 32'hFFFF_FFFF);
        rd(5'h00, v);
        check("R9 dir upper bits", v, LOMASK);
        wr(5'h10, 32'hFF00_0000);
        rd(5'h10, v);
        check("R9 wmask upper ignored", v, 32'h0);
        wr(5'h00, 32'h0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_direction();
        t_data_read();
        t_wmask();
        t_edges();
        t_collision();
        t_irq();
        t_itype();
        t_upper();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule